// File: doc/BRIEF.md
# Vector Element Loop Sequencer

This block sits between the instruction decoder and the issue stage. It takes one decoded instruction per handshake. When the instruction carries the vector prefix, the block expands it into a run of element operations, one for each value of an element-step counter, from the current step up to the vector length minus one. For each element it works out the 7-bit register number of every operand and hands the element to issue over a valid/ready pair. Operands flagged as vector advance by one register per element. Scalar operands keep their base number.

The step counter is architectural state. It lives in a 32-bit loop-state word, together with the vector length. An exception can be taken between any two elements. On that edge the loop-state word is copied into a 32-bit save word, in the same cycle that surrounding logic saves the PC and MSR. A return-from-exception copies the save word back, so the next vector instruction continues at the element where it stopped. Both words can be read and written as SPRs 704 and 720.

Layout of the loop-state word: the step is in bits 6:0 and the vector length is in bits 23:16. All other bits are kept exactly as written.

Top module: `vec_elem_seq`

## Requirements
- R1: After reset, `iss_valid`, `pc_adv` and `illegal` are low and `dec_ready` is high. Reads of SPR 704 and SPR 720 both return 0.
- R2: A prefixed, extendable instruction accepted with step s and vector length n > s presents elements with `iss_step` = s, s+1, ..., n-1, strictly in that order. Each new element appears in the cycle after the previous one is accepted (`iss_valid` && `iss_ready`). No new instruction is accepted while an element is pending.
- R3: For operand slot i (bits i*7+6:i*7 of `dec_base` and `iss_regs`), a slot with `dec_vec[i]`=1 issues (base + step) mod 128. A slot with `dec_vec[i]`=0 issues its base number for every element.
- R4: `iss_ra_zero` is high exactly when the issued number in slot 1 is zero in all 7 bits. A value of 0x20 does not count as zero.
- R5: `iss_cr_en` equals the instruction's `dec_rc` bit. `iss_cr_field` is (`dec_cr_base` + step) mod 128 when `dec_cr_vec` is 1, and `dec_cr_base` otherwise.
- R6: While `iss_valid` is high and `iss_ready` is low, `iss_valid`, `iss_step` and `iss_regs` hold their values.
- R7: In the cycle after the element at step n-1 is accepted, `pc_adv` pulses for one cycle and `iss_valid` drops. The step field then reads 0. When n = 0, `pc_adv` pulses in the cycle after decode acceptance and no element is issued.
- R8: `exc_ack` rises with `exc_req` only when the block is idle or an element is being accepted in that cycle. On that edge the save word takes the loop-state word as updated by that edge, so its step is the next element not yet issued. The block then goes idle without issuing further elements.
- R9: `rfid_req` while idle, with no `exc_req`, copies the save word into the loop-state word. A following prefixed instruction starts at the restored step.
- R10: A prefixed instruction with `dec_ext_ok`=0 produces a one-cycle `illegal` pulse in the next cycle. No element is issued, there is no `pc_adv`, and the loop-state word is unchanged.
- R11: An instruction without the prefix issues exactly one element whose register numbers are the bases, whatever the vector flags say. `pc_adv` follows its acceptance, and the loop-state step is left unchanged.
- R12: While idle, with neither `exc_req` nor `rfid_req` present, `spr_we` writes `spr_wdata` to SPR 704 or 720. `spr_rdata` returns, one cycle after `spr_addr` is presented, the word at 704 or 720, and 0 for any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | Decoded instruction offered |
| dec_ready | output | 1 | Sequencer can take an instruction |
| dec_prefixed | input | 1 | Instruction carries the vector prefix |
| dec_ext_ok | input | 1 | Opcode is in the vector-extendable set |
| dec_vec | input | 3 | Per-slot vector flag |
| dec_base | input | 21 | Per-slot 7-bit base register numbers |
| dec_rc | input | 1 | Implicit CR result requested |
| dec_cr_vec | input | 1 | Implicit CR destination is vector |
| dec_cr_base | input | 7 | Implicit CR destination base |
| iss_valid | output | 1 | Element presented to issue |
| iss_ready | input | 1 | Issue accepts the element |
| iss_step | output | 7 | Step index of the element |
| iss_regs | output | 21 | Per-slot element register numbers |
| iss_ra_zero | output | 1 | Slot 1 number is zero in all 7 bits |
| iss_cr_en | output | 1 | Element writes a CR field |
| iss_cr_field | output | 7 | CR field number for the element |
| pc_adv | output | 1 | Instruction finished, PC may advance |
| illegal | output | 1 | Prefix on a non-extendable opcode |
| exc_req | input | 1 | Exception wants to be taken |
| exc_ack | output | 1 | Exception taken on this edge |
| rfid_req | input | 1 | Return from exception |
| spr_we | input | 1 | SPR write strobe |
| spr_addr | input | 10 | SPR number |
| spr_wdata | input | 32 | SPR write data |
| spr_rdata | output | 32 | SPR read data, one cycle later |

## Verification
The bench sweeps every vector length from 0 to 5 against all eight vector-flag patterns. It uses bases close to 127, so a design that forgot the mod-128 wrap, or stepped a scalar slot, would issue wrong numbers. Stalls are placed on varying elements, to catch a sequencer that moves on or changes its outputs while issue is not ready.

Directed cases cover the zero test on 0x20, which a 5-bit compare would report as zero, and an exception raised while an element is stalled, which must wait. They also cover the saved step, which must name the element after the one accepted, and a resume after restore, which must start mid-vector instead of at 0. Finally, they check the illegal-prefix path, which must neither issue nor advance the PC, and a non-prefixed instruction with vector flags set, which must issue its bases once.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  typedef enum logic {SQ_IDLE = 1'b0, SQ_RUN = 1'b1} seq_state_t;
  // Field positions inside the 32-bit loop-state word
  localparam int STEP_LSB = 0;
  localparam int VL_LSB   = 16;
endpackage

// File: rtl/vseq_elem_map.sv
module vseq_elem_map #(
  parameter int REG_W = 7
) (
  input  logic [REG_W-1:0] base_i,
  input  logic             vec_i,
  input  logic [REG_W-1:0] step_i,
  output logic [REG_W-1:0] num_o
);
  // Vector slots walk the register file, wrapping at its size
  always_comb num_o = vec_i ? base_i + step_i : base_i;
endmodule

// File: rtl/vseq_loop_state.sv
module vseq_loop_state import vseq_pkg::*; #(
  parameter int REG_W     = 7,
  parameter int SPR_W     = 32,
  parameter int ADDR_W    = 10,
  parameter int STATE_SPR = 704,
  parameter int SAVE_SPR  = 720
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_we,
  input  logic [REG_W-1:0]  step_d,
  input  logic              save_en,
  input  logic              restore_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SPR_W-1:0]  wr_data,
  output logic [SPR_W-1:0]  rd_data,
  output logic [REG_W-1:0]  step_o,
  output logic [REG_W:0]    vl_o
);
  localparam int VL_W = REG_W + 1;

  logic [SPR_W-1:0] cur_q, save_q, cur_nxt;
  logic hit_cur, hit_save;

  assign hit_cur  = (addr == ADDR_W'(STATE_SPR));
  assign hit_save = (addr == ADDR_W'(SAVE_SPR));

  always_comb begin
    cur_nxt = cur_q;
    if (restore_en)           cur_nxt = save_q;
    else if (wr_en && hit_cur) cur_nxt = wr_data;
    if (step_we) cur_nxt[STEP_LSB +: REG_W] = step_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q   <= '0;
      save_q  <= '0;
      rd_data <= '0;
    end else begin
      cur_q <= cur_nxt;
      if (save_en)               save_q <= cur_nxt;
      else if (wr_en && hit_save) save_q <= wr_data;
      rd_data <= hit_cur ? cur_q : (hit_save ? save_q : '0);
    end
  end

  assign step_o = cur_q[STEP_LSB +: REG_W];
  assign vl_o   = cur_q[VL_LSB +: VL_W];
endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq import vseq_pkg::*; #(
  parameter int REG_W     = 7,
  parameter int NOPS      = 3,
  parameter int RA_SLOT   = 1,
  parameter int SPR_W     = 32,
  parameter int ADDR_W    = 10,
  parameter int STATE_SPR = 704,
  parameter int SAVE_SPR  = 720
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  dec_valid,
  output logic                  dec_ready,
  input  logic                  dec_prefixed,
  input  logic                  dec_ext_ok,
  input  logic [NOPS-1:0]       dec_vec,
  input  logic [NOPS*REG_W-1:0] dec_base,
  input  logic                  dec_rc,
  input  logic                  dec_cr_vec,
  input  logic [REG_W-1:0]      dec_cr_base,
  output logic                  iss_valid,
  input  logic                  iss_ready,
  output logic [REG_W-1:0]      iss_step,
  output logic [NOPS*REG_W-1:0] iss_regs,
  output logic                  iss_ra_zero,
  output logic                  iss_cr_en,
  output logic [REG_W-1:0]      iss_cr_field,
  output logic                  pc_adv,
  output logic                  illegal,
  input  logic                  exc_req,
  output logic                  exc_ack,
  input  logic                  rfid_req,
  input  logic                  spr_we,
  input  logic [ADDR_W-1:0]     spr_addr,
  input  logic [SPR_W-1:0]      spr_wdata,
  output logic [SPR_W-1:0]      spr_rdata
);
  localparam int VL_W = REG_W + 1;

  seq_state_t state_q;
  logic pre_q, rc_q, crv_q;
  logic [NOPS-1:0] vec_q;
  logic [NOPS*REG_W-1:0] base_q;
  logic [REG_W-1:0] crb_q;

  logic [REG_W-1:0] step_q;
  logic [VL_W-1:0] vl_q;

  logic idle, accept_el, boundary, dec_fire, bad_pfx, zero_vl;
  logic start, last_el, advance, load, restore, spr_ok;
  logic [REG_W-1:0] step_inc, step_nxt, src_step, src_crb, cr_num;
  logic [NOPS*REG_W-1:0] src_base, map_num;
  logic [NOPS-1:0] src_vec;
  logic src_crv;

  assign idle      = (state_q == SQ_IDLE);
  assign accept_el = iss_valid && iss_ready;
  assign boundary  = idle || accept_el;
  assign exc_ack   = exc_req && boundary;
  assign dec_ready = idle && !exc_req && !rfid_req;
  assign dec_fire  = dec_valid && dec_ready;
  assign bad_pfx   = dec_prefixed && !dec_ext_ok;
  assign zero_vl   = (vl_q == '0);
  assign start     = dec_fire && !bad_pfx && !(dec_prefixed && zero_vl);
  assign step_inc  = iss_step + 1'b1;
  assign last_el   = !pre_q || (({1'b0, iss_step} + VL_W'(1)) >= vl_q);
  assign step_nxt  = last_el ? '0 : step_inc;
  assign advance   = accept_el && !last_el && !exc_req;
  assign load      = start || advance;
  assign restore   = idle && rfid_req && !exc_req;
  assign spr_ok    = idle && spr_we && !exc_req && !rfid_req;

  // Source of the next element: fresh decode or the held instruction
  assign src_base = dec_fire ? dec_base : base_q;
  assign src_vec  = dec_fire ? (dec_prefixed ? dec_vec : '0) : vec_q;
  assign src_crv  = dec_fire ? (dec_prefixed && dec_cr_vec) : crv_q;
  assign src_crb  = dec_fire ? dec_cr_base : crb_q;
  assign src_step = dec_fire ? step_q : step_inc;

  for (genvar g = 0; g < NOPS; g++) begin : g_slot
    vseq_elem_map #(.REG_W(REG_W)) u_map (
      .base_i (src_base[g*REG_W +: REG_W]),
      .vec_i  (src_vec[g]),
      .step_i (src_step),
      .num_o  (map_num[g*REG_W +: REG_W])
    );
  end

  vseq_elem_map #(.REG_W(REG_W)) u_cr_map (
    .base_i (src_crb),
    .vec_i  (src_crv),
    .step_i (src_step),
    .num_o  (cr_num)
  );

  vseq_loop_state #(
    .REG_W(REG_W), .SPR_W(SPR_W), .ADDR_W(ADDR_W),
    .STATE_SPR(STATE_SPR), .SAVE_SPR(SAVE_SPR)
  ) u_lstate (
    .clk        (clk),
    .rst        (rst),
    .step_we    (accept_el && pre_q),
    .step_d     (step_nxt),
    .save_en    (exc_ack),
    .restore_en (restore),
    .wr_en      (spr_ok),
    .addr       (spr_addr),
    .wr_data    (spr_wdata),
    .rd_data    (spr_rdata),
    .step_o     (step_q),
    .vl_o       (vl_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= SQ_IDLE;
      iss_valid    <= 1'b0;
      pc_adv       <= 1'b0;
      illegal      <= 1'b0;
      pre_q        <= 1'b0;
      rc_q         <= 1'b0;
      crv_q        <= 1'b0;
      vec_q        <= '0;
      base_q       <= '0;
      crb_q        <= '0;
      iss_regs     <= '0;
      iss_step     <= '0;
      iss_ra_zero  <= 1'b0;
      iss_cr_en    <= 1'b0;
      iss_cr_field <= '0;
    end else begin
      pc_adv  <= (accept_el && last_el) ||
                 (dec_fire && dec_prefixed && !bad_pfx && zero_vl);
      illegal <= dec_fire && bad_pfx;
      if (dec_fire) begin
        pre_q  <= dec_prefixed;
        vec_q  <= src_vec;
        base_q <= dec_base;
        rc_q   <= dec_rc;
        crv_q  <= src_crv;
        crb_q  <= dec_cr_base;
      end
      if (load) begin
        iss_regs     <= map_num;
        iss_step     <= src_step;
        iss_ra_zero  <= (map_num[RA_SLOT*REG_W +: REG_W] == '0);
        iss_cr_field <= cr_num;
        iss_cr_en    <= dec_fire ? dec_rc : rc_q;
      end
      if (start) begin
        state_q   <= SQ_RUN;
        iss_valid <= 1'b1;
      end else if (accept_el && !advance) begin
        state_q   <= SQ_IDLE;
        iss_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vseq_checker.sv
module vseq_checker #(
  parameter int REG_W = 7,
  parameter int NOPS  = 3
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  iss_valid,
  input logic                  iss_ready,
  input logic [REG_W-1:0]      iss_step,
  input logic [NOPS*REG_W-1:0] iss_regs,
  input logic                  exc_ack,
  input logic                  illegal,
  input logic                  pc_adv,
  input logic                  dec_ready
);
  // R6: a stalled element is held unchanged
  a_r6_hold_stalled: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && !iss_ready) |=> (iss_valid && $stable(iss_regs) && $stable(iss_step)));

  // R2: an accepted element is followed by the next step or by nothing
  a_r2_step_order: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_ready && !exc_ack) |=>
      (!iss_valid || (iss_step == REG_W'($past(iss_step) + 1'b1))));

  // R2: decode is never accepted while an element is pending
  a_r2_one_in_flight: assert property (@(posedge clk) disable iff (rst)
    dec_ready |-> !iss_valid);

  // R8: exceptions only at an element boundary
  a_r8_boundary_only: assert property (@(posedge clk) disable iff (rst)
    exc_ack |-> (!iss_valid || iss_ready));

  // R10: illegal prefix neither issues nor advances the PC
  a_r10_illegal_quiet: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!iss_valid && !pc_adv));
endmodule

bind vec_elem_seq vseq_checker #(.REG_W(REG_W), .NOPS(NOPS)) u_vseq_chk (
  .clk       (clk),
  .rst       (rst),
  .iss_valid (iss_valid),
  .iss_ready (iss_ready),
  .iss_step  (iss_step),
  .iss_regs  (iss_regs),
  .exc_ack   (exc_ack),
  .illegal   (illegal),
  .pc_adv    (pc_adv),
  .dec_ready (dec_ready)
);

// File: tb/vec_elem_seq_tb.sv
module vec_elem_seq_tb_top;
  localparam int CYC = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dec_valid = 0, dec_prefixed = 0, dec_ext_ok = 0, dec_rc = 0, dec_cr_vec = 0;
  logic [2:0] dec_vec = '0;
  logic [20:0] dec_base = '0;
  logic [6:0] dec_cr_base = '0;
  logic iss_ready = 0, exc_req = 0, rfid_req = 0, spr_we = 0;
  logic [9:0] spr_addr = '0;
  logic [31:0] spr_wdata = '0;
  logic dec_ready, iss_valid, iss_ra_zero, iss_cr_en, pc_adv, illegal, exc_ack;
  logic [6:0] iss_step, iss_cr_field;
  logic [20:0] iss_regs;
  logic [31:0] spr_rdata;

  int n_chk = 0;
  int n_fail = 0;

  always #(CYC/2) clk = ~clk;

  vec_elem_seq dut_i (
    .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_ready(dec_ready),
    .dec_prefixed(dec_prefixed), .dec_ext_ok(dec_ext_ok), .dec_vec(dec_vec),
    .dec_base(dec_base), .dec_rc(dec_rc), .dec_cr_vec(dec_cr_vec),
    .dec_cr_base(dec_cr_base), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_step(iss_step), .iss_regs(iss_regs), .iss_ra_zero(iss_ra_zero),
    .iss_cr_en(iss_cr_en), .iss_cr_field(iss_cr_field), .pc_adv(pc_adv),
    .illegal(illegal), .exc_req(exc_req), .exc_ack(exc_ack), .rfid_req(rfid_req),
    .spr_we(spr_we), .spr_addr(spr_addr), .spr_wdata(spr_wdata), .spr_rdata(spr_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] expn(input logic [6:0] b, input logic v, input int e);
    return v ? 7'(int'(b) + e) : b;
  endfunction

  function automatic logic [31:0] lword(input int vl, input int st);
    return (32'(vl) << 16) | 32'(st);
  endfunction

  task automatic spr_write(input int a, input logic [31:0] d);
    @(negedge clk);
    spr_we = 1; spr_addr = 10'(a); spr_wdata = d;
    @(negedge clk);
    spr_we = 0;
  endtask

  task automatic spr_read(input int a, output logic [31:0] d);
    @(negedge clk);
    spr_addr = 10'(a);
    @(negedge clk);
    d = spr_rdata;
  endtask

  task automatic offer(input logic pfx, input logic ext, input logic [2:0] v,
                       input logic [6:0] b0, input logic [6:0] b1, input logic [6:0] b2,
                       input logic rc, input logic crv, input logic [6:0] crb);
    @(negedge clk);
    dec_valid = 1; dec_prefixed = pfx; dec_ext_ok = ext; dec_vec = v;
    dec_base = {b2, b1, b0}; dec_rc = rc; dec_cr_vec = crv; dec_cr_base = crb;
    #1 chk("R2 dec_ready when idle", 32'(dec_ready), 1);
    @(negedge clk);
    dec_valid = 0;
  endtask

  // Drives a prefixed instruction and walks its elements start..vl-1
  task automatic go_vec(input int vl, input int st, input logic [2:0] v,
                        input logic [6:0] b0, input logic [6:0] b1, input logic [6:0] b2,
                        input logic rc, input logic crv, input logic [6:0] crb, input int seed);
    logic [6:0] bs [3];
    logic [31:0] rd;
    bs[0] = b0; bs[1] = b1; bs[2] = b2;
    offer(1, 1, v, b0, b1, b2, rc, crv, crb);
    if (vl == 0) begin
      chk("R7 pc_adv on VL=0", 32'(pc_adv), 1);
      chk("R7 no issue on VL=0", 32'(iss_valid), 0);
    end else begin
      for (int e = st; e < vl; e++) begin
        chk("R2 element valid", 32'(iss_valid), 1);
        chk("R2 element step", 32'(iss_step), 32'(e));
        for (int s = 0; s < 3; s++)
          chk("R3 slot number", 32'(iss_regs[s*7 +: 7]), 32'(expn(bs[s], v[s], e)));
        chk("R4 ra zero flag", 32'(iss_ra_zero), 32'(expn(b1, v[1], e) == 7'd0));
        chk("R5 cr enable", 32'(iss_cr_en), 32'(rc));
        chk("R5 cr field", 32'(iss_cr_field), 32'(expn(crb, crv, e)));
        if ((e + seed) % 3 == 0) begin
          iss_ready = 0;
          @(negedge clk);
          chk("R6 held valid", 32'(iss_valid), 1);
          chk("R6 held step", 32'(iss_step), 32'(e));
          chk("R6 held slot0", 32'(iss_regs[6:0]), 32'(expn(b0, v[0], e)));
        end
        iss_ready = 1;
        @(negedge clk);
        iss_ready = 0;
        chk("R7 pc_adv timing", 32'(pc_adv), 32'(e == vl - 1));
      end
      chk("R7 idle after last", 32'(iss_valid), 0);
    end
    spr_read(704, rd);
    chk("R7 step back to zero", rd, lword(vl, 0));
  endtask

  initial begin
    #(CYC * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 iss_valid reset", 32'(iss_valid), 0);
    chk("R1 pc_adv reset", 32'(pc_adv), 0);
    chk("R1 illegal reset", 32'(illegal), 0);
    chk("R1 dec_ready reset", 32'(dec_ready), 1);
    spr_read(704, rd); chk("R1 loop state reset", rd, 0);
    spr_read(720, rd); chk("R1 save reset", rd, 0);

    // R12 SPR access
    spr_write(704, 32'hA5AB_0003);
    spr_read(704, rd); chk("R12 loop state readback", rd, 32'hA5AB_0003);
    spr_write(720, 32'h1234_5678);
    spr_read(720, rd); chk("R12 save readback", rd, 32'h1234_5678);
    spr_read(705, rd); chk("R12 other address", rd, 0);

    // Sweep R2 R3 R5 R6 R7 over lengths and vector patterns
    for (int vl = 0; vl < 6; vl++)
      for (int m = 0; m < 8; m++) begin
        spr_write(704, lword(vl, 0));
        go_vec(vl, 0, 3'(m), 7'(vl * 37 + m * 11 + 120), 7'(126 - m), 7'(m * 16 + vl),
               m[1], m[0], 7'(125 + vl), vl + m);
      end

    // R4 full-width zero compare
    spr_write(704, lword(2, 0));
    go_vec(2, 0, 3'b000, 7'd5, 7'h20, 7'd9, 0, 0, 7'd1, 1);
    spr_write(704, lword(3, 0));
    go_vec(3, 0, 3'b000, 7'd5, 7'h00, 7'd9, 1, 1, 7'd1, 1);
    spr_write(704, lword(4, 0));
    go_vec(4, 0, 3'b010, 7'd5, 7'd126, 7'd9, 1, 0, 7'd1, 2);

    // R10 illegal prefix
    spr_write(704, lword(4, 1));
    offer(1, 0, 3'b111, 7'd1, 7'd2, 7'd3, 0, 0, 7'd0);
    chk("R10 illegal pulse", 32'(illegal), 1);
    chk("R10 no issue", 32'(iss_valid), 0);
    chk("R10 no pc_adv", 32'(pc_adv), 0);
    spr_read(704, rd); chk("R10 loop state kept", rd, lword(4, 1));

    // R11 plain instruction
    spr_write(704, lword(6, 2));
    offer(0, 0, 3'b111, 7'd40, 7'd50, 7'd60, 0, 0, 7'd0);
    chk("R11 one element", 32'(iss_valid), 1);
    chk("R11 base regs", 32'(iss_regs), 32'({7'd60, 7'd50, 7'd40}));
    iss_ready = 1; @(negedge clk); iss_ready = 0;
    chk("R11 pc_adv", 32'(pc_adv), 1);
    chk("R11 single element only", 32'(iss_valid), 0);
    spr_read(704, rd); chk("R11 step kept", rd, lword(6, 2));

    // R8 exception mid-vector, R9 resume
    spr_write(704, lword(5, 0));
    offer(1, 1, 3'b111, 7'd10, 7'd20, 7'd30, 0, 0, 7'd0);
    for (int e = 0; e < 2; e++) begin
      iss_ready = 1; @(negedge clk); iss_ready = 0;
    end
    chk("R8 at element 2", 32'(iss_step), 2);
    exc_req = 1;
    #1 chk("R8 no ack while stalled", 32'(exc_ack), 0);
    iss_ready = 1;
    #1 chk("R8 ack on acceptance", 32'(exc_ack), 1);
    @(negedge clk);
    exc_req = 0; iss_ready = 0;
    chk("R8 loop abandoned", 32'(iss_valid), 0);
    chk("R8 no pc_adv", 32'(pc_adv), 0);
    spr_read(720, rd); chk("R8 saved step", rd, lword(5, 3));
    spr_write(704, lword(2, 0));
    @(negedge clk); rfid_req = 1;
    @(negedge clk); rfid_req = 0;
    spr_read(704, rd); chk("R9 restored word", rd, lword(5, 3));
    go_vec(5, 3, 3'b111, 7'd10, 7'd20, 7'd30, 0, 0, 7'd0, 0);

    // R8 exception while idle
    spr_write(704, lword(7, 4));
    @(negedge clk); exc_req = 1;
    #1 chk("R8 idle ack", 32'(exc_ack), 1);
    chk("R8 decode blocked", 32'(dec_ready), 0);
    @(negedge clk); exc_req = 0;
    spr_read(720, rd); chk("R8 idle save", rd, lword(7, 4));

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule